// File: doc/BRIEF.md
# Input Edge-Count Timer Channel

This block is one channel of a general-purpose timer, set up to count transitions on an asynchronous capture input until a programmed target count is reached. The capture input is synchronised, then debounced by a qualifier: a new level is accepted only after it has been sampled for two consecutive system clock cycles. Software picks which accepted edges are counted: rising, falling or both. The count register is 24 bits wide by default. A 16-bit low field is extended by an 8-bit prescale field, which forms the upper bits. The load value and the target value are split into the same two fields.

Two counting directions are supported. When counting down, enabling the channel loads the full load value. Each counted edge subtracts one. When the count reaches the target, the channel reloads the load value and turns itself off. It then ignores edges until software enables it again. When counting up, enabling loads zero. On reaching the target, the channel wraps back to zero and keeps running. Each match sets a sticky status flag, which software clears. It also gives a maskable interrupt and a one-cycle DMA request pulse.

Top module: `edge_count_timer`

## Requirements
- R1: After reset, `count` is 0, `run_en` is 0, and `raw_match`, `irq` and `dma_trig` are all 0.
- R2: A cycle with `ctl_wr`=1 and `ctl_en`=1 sets `run_en`. In the same write, the count is loaded with {`load_pre`,`load_lo`} when `ctl_up`=0 (down), or with 0 when `ctl_up`=1 (up).
- R3: `ctl_edge` is latched on a control write and picks the counted edges: 2'b00 counts rising edges only, 2'b01 counts falling edges only, and 2'b10 or 2'b11 count both.
- R4: A new input level counts as an edge only after the synchronised input has shown it for two consecutive cycles. A pulse or gap one cycle long is not counted. Alternating two cycles high and two cycles low counts every edge.
- R5: While enabled, each counted edge changes the count by exactly one: minus one when down, plus one when up.
- R6: When a down-count step reaches {`match_pre`,`match_lo`}, the count reloads {`load_pre`,`load_lo`} and `run_en` clears. Later edges are ignored. With load 0x000A, target 0x0006 and both edges selected, exactly four edges are counted.
- R7: When an up-count step reaches the target, the count returns to 0 and `run_en` stays 1.
- R8: `raw_match` is set by a match and stays set until a cycle with `irq_clr`=1 and no match. If a match and `irq_clr` fall in the same cycle, the flag is set.
- R9: `irq` is 1 exactly when `raw_match` is 1 and `irq_mask` is 1.
- R10: `dma_trig` is high for one cycle per match, in the same cycle that `raw_match` rises, whatever the value of `irq_mask`.
- R11: The count and the target comparison cover all 24 bits. A borrow from the low field takes one from the prescale field.
- R12: A control write with `ctl_en`=0 clears `run_en`. While `run_en` is 0, edges leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_cap | input | 1 | Asynchronous capture input |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_en | input | 1 | Enable value written by `ctl_wr` |
| ctl_up | input | 1 | Direction written by `ctl_wr`: 1 up, 0 down |
| ctl_edge | input | 2 | Edge select written by `ctl_wr` |
| load_lo | input | CNT_W (16) | Low field of the load value |
| load_pre | input | PRE_W (8) | Prescale (upper) field of the load value |
| match_lo | input | CNT_W (16) | Low field of the target value |
| match_pre | input | PRE_W (8) | Prescale (upper) field of the target value |
| irq_mask | input | 1 | Match interrupt enable |
| irq_clr | input | 1 | Clears the match status flag |
| run_en | output | 1 | Current enable state |
| count | output | CNT_W+PRE_W (24) | Current event count |
| raw_match | output | 1 | Sticky match status |
| irq | output | 1 | Masked match interrupt |
| dma_trig | output | 1 | One-cycle DMA request on each match |

## Verification
The embedded properties check the following on every cycle:
- The status flag holds or clears as the set and clear inputs dictate, and a DMA pulse always comes with a set flag.
- A DMA pulse lasts one cycle.
- A counted step moves the count by one.
- A disabled channel keeps its count.
- A down match turns the channel off with the load value restored.
- An up match wraps to zero while staying enabled.
- The qualifier never gives a rise followed at once by a fall.

Only the bench scenarios can show the behaviour that depends on the input waveform:
- Which edges each select code counts, and that one-cycle glitches are rejected.
- The exact four-edge worked case and the borrow across the prescale field.
- The mask's effect on the interrupt but not on the DMA pulse.
- That a clear arriving in the very cycle of a match loses.

// File: rtl/ect_pkg.sv
package ect_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE  = 2'b00,
      EDGE_FALL  = 2'b01,
      EDGE_BOTH  = 2'b10,
      EDGE_BOTH2 = 2'b11
   } edge_sel_e;

   function automatic logic edge_pass(input edge_sel_e sel, input logic rise, input logic fall);
      case (sel)
         EDGE_RISE: edge_pass = rise;
         EDGE_FALL: edge_pass = fall;
         default:   edge_pass = rise | fall;
      endcase
   endfunction

endpackage

// File: rtl/ect_edge_qual.sv
module ect_edge_qual #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_async,
   output logic rise_q,
   output logic fall_q
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ect_edge_qual: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_r;
   logic                   smp;
   logic                   smp_d;
   logic                   level_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_r[0] <= 1'b0;
               else        sync_r[0] <= in_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_r[i] <= 1'b0;
               else        sync_r[i] <= sync_r[i-1];
            end
         end
      end
   endgenerate

   assign smp = sync_r[SYNC_STAGES-1];

   // a level change is accepted once two successive samples agree on it
   assign rise_q = !level_q &&  smp &&  smp_d;
   assign fall_q =  level_q && !smp && !smp_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_d   <= 1'b0;
         level_q <= 1'b0;
      end else begin
         smp_d <= smp;
         if (rise_q)      level_q <= 1'b1;
         else if (fall_q) level_q <= 1'b0;
      end
   end

   p_rise_then_no_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |=> !fall_q && !rise_q);
   p_fall_then_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_q |=> !rise_q && !fall_q);

endmodule

// File: rtl/ect_counter.sv
module ect_counter
   import ect_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ctl_wr,
   input  logic                     ctl_en,
   input  logic                     ctl_up,
   input  logic [1:0]               ctl_edge,
   input  logic [CNT_W+PRE_W-1:0]   load_val,
   input  logic [CNT_W+PRE_W-1:0]   match_val,
   input  logic                     rise_q,
   input  logic                     fall_q,
   output logic                     run_en,
   output logic [CNT_W+PRE_W-1:0]   count,
   output logic                     match_evt
);

   localparam int TOT_W = CNT_W + PRE_W;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("ect_counter: CNT_W must be at least 2");
      end
      if (PRE_W < 1) begin : g_bad_pre
         $error("ect_counter: PRE_W must be at least 1");
      end
   endgenerate

   logic [TOT_W-1:0] cnt_q;
   logic [TOT_W-1:0] cnt_nxt;
   logic             en_q;
   logic             up_q;
   edge_sel_e        sel_q;
   logic             step;

   assign step      = en_q && !ctl_wr && edge_pass(sel_q, rise_q, fall_q);
   assign cnt_nxt   = up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
   assign match_evt = step && (cnt_nxt == match_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
         up_q  <= 1'b0;
         sel_q <= EDGE_RISE;
      end else if (ctl_wr) begin
         en_q  <= ctl_en;
         up_q  <= ctl_up;
         sel_q <= edge_sel_e'(ctl_edge);
         if (ctl_en) cnt_q <= ctl_up ? '0 : load_val;
      end else if (step) begin
         if (match_evt) begin
            cnt_q <= up_q ? '0 : load_val;
            if (!up_q) en_q <= 1'b0;
         end else begin
            cnt_q <= cnt_nxt;
         end
      end
   end

   assign run_en = en_q;
   assign count  = cnt_q;

   p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_en |=> en_q && (cnt_q == ($past(ctl_up) ? '0 : $past(load_val))));
   p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step && up_q && !match_evt |=> cnt_q == $past(cnt_q) + 1'b1);
   p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step && !up_q && !match_evt |=> cnt_q == $past(cnt_q) - 1'b1);
   p_down_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt && !up_q |=> !en_q && cnt_q == $past(load_val));
   p_up_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt && up_q |=> en_q && cnt_q == '0);
   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q && !ctl_wr |=> $stable(cnt_q) && !en_q);

endmodule

// File: rtl/ect_status.sv
module ect_status (
   input  logic clk,
   input  logic rst_n,
   input  logic match_evt,
   input  logic irq_mask,
   input  logic irq_clr,
   output logic raw_match,
   output logic irq,
   output logic dma_trig
);

   logic raw_q;
   logic dma_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         dma_q <= 1'b0;
      end else begin
         // a set in the same cycle as a clear wins
         raw_q <= match_evt | (raw_q & ~irq_clr);
         dma_q <= match_evt;
      end
   end

   assign raw_match = raw_q;
   assign irq       = raw_q & irq_mask;
   assign dma_trig  = dma_q;

   p_raw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      raw_q && !irq_clr |=> raw_q);
   p_raw_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      raw_q && irq_clr && !match_evt |=> !raw_q);
   p_dma_with_raw_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_q |-> raw_q);
   p_dma_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_q |=> !dma_q);

endmodule

// File: rtl/edge_count_timer.sv
module edge_count_timer #(
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_cap,
   input  logic                   ctl_wr,
   input  logic                   ctl_en,
   input  logic                   ctl_up,
   input  logic [1:0]             ctl_edge,
   input  logic [CNT_W-1:0]       load_lo,
   input  logic [PRE_W-1:0]       load_pre,
   input  logic [CNT_W-1:0]       match_lo,
   input  logic [PRE_W-1:0]       match_pre,
   input  logic                   irq_mask,
   input  logic                   irq_clr,
   output logic                   run_en,
   output logic [CNT_W+PRE_W-1:0] count,
   output logic                   raw_match,
   output logic                   irq,
   output logic                   dma_trig
);

   localparam int TOT_W = CNT_W + PRE_W;

   logic             rise_q;
   logic             fall_q;
   logic             match_evt;
   logic [TOT_W-1:0] load_val;
   logic [TOT_W-1:0] match_val;

   assign load_val  = {load_pre, load_lo};
   assign match_val = {match_pre, match_lo};

   ect_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) i_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_async (in_cap),
      .rise_q   (rise_q),
      .fall_q   (fall_q)
   );

   ect_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_en    (ctl_en),
      .ctl_up    (ctl_up),
      .ctl_edge  (ctl_edge),
      .load_val  (load_val),
      .match_val (match_val),
      .rise_q    (rise_q),
      .fall_q    (fall_q),
      .run_en    (run_en),
      .count     (count),
      .match_evt (match_evt)
   );

   ect_status i_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .match_evt (match_evt),
      .irq_mask  (irq_mask),
      .irq_clr   (irq_clr),
      .raw_match (raw_match),
      .irq       (irq),
      .dma_trig  (dma_trig)
   );

   p_match_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> raw_match && dma_trig);

endmodule

// File: tb/test_edge_count_timer.sv
`timescale 1ns/1ps
module test_edge_count_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_cap = 1'b0;
   logic        ctl_wr = 1'b0;
   logic        ctl_en = 1'b0;
   logic        ctl_up = 1'b0;
   logic [1:0]  ctl_edge = 2'b00;
   logic [15:0] load_lo = '0;
   logic [7:0]  load_pre = '0;
   logic [15:0] match_lo = '0;
   logic [7:0]  match_pre = '0;
   logic        irq_mask = 1'b0;
   logic        irq_clr = 1'b0;
   logic        run_en;
   logic [23:0] count;
   logic        raw_match;
   logic        irq;
   logic        dma_trig;

   int n_chk = 0;
   int n_fail = 0;
   int dma_cnt = 0;
   int dma_wide = 0;
   logic dma_prev = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   edge_count_timer i_edge_count_timer (
      .clk(clk), .rst_n(rst_n), .in_cap(in_cap),
      .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_up(ctl_up), .ctl_edge(ctl_edge),
      .load_lo(load_lo), .load_pre(load_pre), .match_lo(match_lo), .match_pre(match_pre),
      .irq_mask(irq_mask), .irq_clr(irq_clr),
      .run_en(run_en), .count(count), .raw_match(raw_match), .irq(irq), .dma_trig(dma_trig)
   );

   always @(negedge clk) begin
      if (dma_trig) dma_cnt++;
      if (dma_trig && dma_prev) dma_wide++;
      dma_prev = dma_trig;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic lvl(input logic v, input int n);
      in_cap = v;
      cyc(n);
   endtask

   task automatic wr_ctl(input logic en, input logic up, input logic [1:0] sel);
      ctl_wr = 1'b1; ctl_en = en; ctl_up = up; ctl_edge = sel;
      cyc(1);
      ctl_wr = 1'b0;
   endtask

   task automatic clr_flag();
      irq_clr = 1'b1;
      cyc(1);
      irq_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 count", count, 0);
      chk("R1 run_en", run_en, 0);
      chk("R1 raw_match", raw_match, 0);
      chk("R1 irq", irq, 0);
      chk("R1 dma_trig", dma_trig, 0);
   endtask

   task automatic t_down_example();
      int d0;
      load_lo = 16'h000A; load_pre = 8'h00; match_lo = 16'h0006; match_pre = 8'h00;
      irq_mask = 1'b1;
      wr_ctl(1'b1, 1'b0, 2'b10);
      chk("R2 down load", count, 24'h00000A);
      chk("R2 enabled", run_en, 1);
      d0 = dma_cnt;
      lvl(1'b1, 4); lvl(1'b0, 8);
      chk("R5 down two edges", count, 24'h000008);
      lvl(1'b1, 4); lvl(1'b0, 8);
      chk("R6 reload", count, 24'h00000A);
      chk("R6 auto disable", run_en, 0);
      chk("R8 raw set", raw_match, 1);
      chk("R9 irq masked on", irq, 1);
      chk("R10 one dma", dma_cnt - d0, 1);
      lvl(1'b1, 4); lvl(1'b0, 8);
      chk("R6 later edges ignored", count, 24'h00000A);
      chk("R6 no further dma", dma_cnt - d0, 1);
   endtask

   task automatic t_clear();
      clr_flag();
      cyc(1);
      chk("R8 cleared", raw_match, 0);
      chk("R9 irq off", irq, 0);
   endtask

   task automatic t_up_rising();
      int d0;
      match_lo = 16'h0003; match_pre = 8'h00; irq_mask = 1'b0;
      wr_ctl(1'b1, 1'b1, 2'b00);
      chk("R2 up load", count, 0);
      d0 = dma_cnt;
      for (int i = 0; i < 2; i++) begin
         lvl(1'b1, 4); lvl(1'b0, 6);
      end
      chk("R3 rising only", count, 2);
      lvl(1'b1, 4); lvl(1'b0, 6);
      chk("R7 wrap", count, 0);
      chk("R7 stays enabled", run_en, 1);
      chk("R8 raw set up", raw_match, 1);
      chk("R9 mask blocks irq", irq, 0);
      chk("R10 dma unmasked", dma_cnt - d0, 1);
      irq_mask = 1'b1;
      cyc(1);
      chk("R9 mask on", irq, 1);
      irq_mask = 1'b0;
      lvl(1'b1, 4); lvl(1'b0, 6);
      chk("R7 continues", count, 1);
      clr_flag();
   endtask

   task automatic t_down_falling();
      load_lo = 16'h0005; load_pre = 8'h00; match_lo = 16'h0002; match_pre = 8'h00;
      wr_ctl(1'b1, 1'b0, 2'b01);
      chk("R2 reload on enable", count, 5);
      lvl(1'b1, 6);
      chk("R3 rise not counted", count, 5);
      lvl(1'b0, 6);
      chk("R3 fall counted", count, 4);
   endtask

   task automatic t_glitch();
      match_lo = 16'h0064; match_pre = 8'h00;
      wr_ctl(1'b1, 1'b1, 2'b11);
      lvl(1'b1, 1); lvl(1'b0, 6);
      chk("R4 short high rejected", count, 0);
      lvl(1'b1, 2); lvl(1'b0, 6);
      chk("R4 two-cycle pulse", count, 2);
      for (int i = 0; i < 4; i++) begin
         lvl(1'b1, 2); lvl(1'b0, 2);
      end
      cyc(6);
      chk("R4 quarter rate", count, 10);
      lvl(1'b1, 4); lvl(1'b0, 1); lvl(1'b1, 6);
      chk("R4 short low rejected", count, 11);
      lvl(1'b0, 6);
      chk("R3 code 11 both", count, 12);
   endtask

   task automatic t_prescale();
      load_lo = 16'h0001; load_pre = 8'h01; match_lo = 16'hFFFE; match_pre = 8'h00;
      wr_ctl(1'b1, 1'b0, 2'b10);
      chk("R11 full load", count, 24'h010001);
      lvl(1'b1, 4); lvl(1'b0, 8);
      chk("R11 borrow", count, 24'h00FFFF);
      chk("R11 no early match", run_en, 1);
      lvl(1'b1, 8);
      chk("R11 match reload", count, 24'h010001);
      chk("R11 stopped", run_en, 0);
      lvl(1'b0, 6);
      clr_flag();
   endtask

   task automatic t_disable();
      match_lo = 16'h0032; match_pre = 8'h00;
      wr_ctl(1'b1, 1'b1, 2'b00);
      lvl(1'b1, 4); lvl(1'b0, 6);
      chk("R5 up step", count, 1);
      wr_ctl(1'b0, 1'b1, 2'b00);
      chk("R12 disabled", run_en, 0);
      for (int i = 0; i < 2; i++) begin
         lvl(1'b1, 4); lvl(1'b0, 6);
      end
      chk("R12 count frozen", count, 1);
   endtask

   task automatic t_clr_priority();
      match_lo = 16'h0001; match_pre = 8'h00;
      wr_ctl(1'b1, 1'b1, 2'b00);
      cyc(4);
      chk("R8 flag clear before", raw_match, 0);
      in_cap = 1'b1;
      cyc(3);
      irq_clr = 1'b1;
      cyc(1);
      irq_clr = 1'b0;
      cyc(1);
      chk("R8 set beats clear", raw_match, 1);
      lvl(1'b0, 6);
      clr_flag();
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_down_example();
      t_clear();
      t_up_rising();
      t_down_falling();
      t_glitch();
      t_prescale();
      t_disable();
      t_clr_priority();
      chk("R10 single-cycle dma", dma_wide, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule